// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block is a sum-of-products engine whose AND plane and OR plane are both taken from configuration bits held in registers. Each of the `N_IN` inputs is offered to every product term in true and complemented form. Each of the `N_PT` product terms ANDs the literals enabled for it. Each of the `N_OUT` outputs ORs the product terms enabled for it, so one term can feed several outputs at once.

Configuration arrives one bit per clock on `cfg_bit` while `load_en` is high. The AND-plane bits come first and the OR-plane bits follow. Evaluation is combinational from the stored bits. A small control state machine gates the outputs. It has three states:
- `ST_BLANK`: not fully configured.
- `ST_SHIFT`: loading.
- `ST_ACTIVE`: evaluating.

Its transitions are:
- any state goes to `ST_SHIFT` at an edge where `load_en` is high;
- otherwise it goes to `ST_ACTIVE` when the bit count is full;
- otherwise it goes to `ST_BLANK`.

The defaults are 16 inputs, 32 product terms and 8 outputs. This gives 2·16·32 = 1024 AND-plane links and 32·8 = 256 OR-plane links.

Top module: `cfg_pla`

## Requirements
- R1: After reset, `y` is all zero and `config_done` is 0.
- R2: Configuration is a stream of TOTAL = 2·N_IN·N_PT + N_PT·N_OUT bits, shifted one per rising clock edge while `load_en` is high. Once at least TOTAL bits have been shifted, the last TOTAL bits form the configuration, numbered 0 to TOTAL-1 in arrival order (bit 0 arrives first).
- R3: AND-plane bit `t·2·N_IN + 2·i` enables the true literal of input `i` in term `t`. Bit `t·2·N_IN + 2·i + 1` enables the complemented literal of input `i` in term `t`.
- R4: OR-plane bit `2·N_IN·N_PT + o·N_PT + t` connects term `t` to output `o`. A term may be connected to any number of outputs.
- R5: A product term with no literal enabled evaluates to 0, and a term enabling both literals of one input evaluates to 0.
- R6: While `load_en` is high, and at the first edge after it falls, `y` is all zero.
- R7: `config_done` rises after the edge that shifts the TOTAL-th bit since reset, not earlier, and stays high until reset.
- R8: `y` is all zero whenever `config_done` is 0.
- R9: When the block is active, `y[o]` equals the OR, over terms connected to `o`, of each term's AND of its enabled literals, for every input pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Shift enable for the configuration stream |
| cfg_bit | input | 1 | Serial configuration data |
| x | input | N_IN | Logic inputs |
| y | output | N_OUT | Sum-of-products outputs |
| config_done | output | 1 | A full configuration has been shifted in since reset |

## Verification
A misplaced or lost configuration bit shows up as a wrong value of `y`. It appears only for the input patterns whose literals or term connections that bit controls, so the checks sweep every input combination for each loaded configuration. A wrong controller state or bit count shows up as `y` or `config_done` being non-zero one cycle too early or late around the edge where loading ends. The checks therefore sample on the first cycle after each load boundary.

// File: rtl/pla_pkg.sv
package pla_pkg;
    typedef enum logic [1:0] {
        ST_BLANK  = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_ACTIVE = 2'd2
    } pla_state_e;
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
    parameter int TOTAL = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [TOTAL-1:0] cfg_q,
    output logic             full
);
    localparam int CW = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt_q;

    // newest bit enters at the top; after TOTAL shifts the first bit sits at index 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (shift_en) begin
            cfg_q <= {din, cfg_q[TOTAL-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (shift_en && (cnt_q != CW'(TOTAL))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == CW'(TOTAL));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN = 16,
    parameter int N_PT = 32
) (
    input  logic [2*N_IN*N_PT-1:0] and_cfg,
    input  logic [N_IN-1:0]        x,
    output logic [N_PT-1:0]        pt
);
    localparam int LW = 2 * N_IN;

    logic [LW-1:0] lits;

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            assign lits[2*i]   = x[i];
            assign lits[2*i+1] = ~x[i];
        end
        for (genvar t = 0; t < N_PT; t++) begin : g_term
            logic [LW-1:0] en;
            assign en    = and_cfg[t*LW +: LW];
            assign pt[t] = (|en) & (&(lits | ~en));
        end
    endgenerate
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_PT  = 32,
    parameter int N_OUT = 8
) (
    input  logic [N_PT*N_OUT-1:0] or_cfg,
    input  logic [N_PT-1:0]       pt,
    output logic [N_OUT-1:0]      sum
);
    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_out
            assign sum[o] = |(pt & or_cfg[o*N_PT +: N_PT]);
        end
    endgenerate
endmodule

// File: rtl/pla_ctrl.sv
module pla_ctrl
    import pla_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_en,
    input  logic       full,
    output pla_state_e state_q,
    output logic       out_en
);
    pla_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK, ST_SHIFT, ST_ACTIVE: begin
                if (load_en)   state_d = ST_SHIFT;
                else if (full) state_d = ST_ACTIVE;
                else           state_d = ST_BLANK;
            end
            default: state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_ACTIVE: out_en = 1'b1;
            default:   out_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_pla.sv
module cfg_pla
    import pla_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int N_PT  = 32,
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  x,
    output logic [N_OUT-1:0] y,
    output logic             config_done
);
    localparam int AND_BITS = 2 * N_IN * N_PT;
    localparam int OR_BITS  = N_PT * N_OUT;
    localparam int TOTAL    = AND_BITS + OR_BITS;

    logic [TOTAL-1:0] cfg_q;
    logic             full;
    logic [N_PT-1:0]  pt;
    logic [N_OUT-1:0] sum;
    logic             out_en;
    pla_state_e       state_q;

    pla_cfg_chain #(.TOTAL(TOTAL)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (load_en),
        .din      (cfg_bit),
        .cfg_q    (cfg_q),
        .full     (full)
    );

    pla_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .full    (full),
        .state_q (state_q),
        .out_en  (out_en)
    );

    pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .and_cfg (cfg_q[AND_BITS-1:0]),
        .x       (x),
        .pt      (pt)
    );

    pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
        .or_cfg (cfg_q[TOTAL-1:AND_BITS]),
        .pt     (pt),
        .sum    (sum)
    );

    assign y           = out_en ? sum : '0;
    assign config_done = full;
endmodule

// File: rtl/pla_checker.sv
module pla_checker
    import pla_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic [N_OUT-1:0] y,
    input logic             config_done,
    input pla_state_e       state_q
);
    // R6: outputs silent during loading and at the edge after it
    p_quiet_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (y == '0));

    // R8: no output before a full configuration
    p_blank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !config_done |-> (y == '0));

    // R7: done is sticky
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        config_done |=> config_done);

    // R7: done only rises from a shift
    p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(config_done) |-> $past(load_en));

    // R6: controller never active while loading was seen at the last edge
    p_no_active_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (state_q != ST_ACTIVE));
endmodule

bind cfg_pla pla_checker #(.N_OUT(N_OUT)) u_pla_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .y           (y),
    .config_done (config_done),
    .state_q     (state_q)
);

// File: tb/tb_cfg_pla.sv
`timescale 1ns/1ps
module tb_cfg_pla;
    localparam int NI    = 3;
    localparam int NP    = 4;
    localparam int NO    = 2;
    localparam int ANDB  = 2 * NI * NP;
    localparam int TOTAL = ANDB + NP * NO;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic          cfg_bit = 1'b0;
    logic [NI-1:0] x = '0;
    logic [NO-1:0] y;
    logic          config_done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cfg_pla #(.N_IN(NI), .N_PT(NP), .N_OUT(NO)) dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_bit(cfg_bit),
        .x(x), .y(y), .config_done(config_done)
    );

    function automatic logic [NO-1:0] model(input logic [TOTAL-1:0] c, input logic [NI-1:0] xi);
        logic [NP-1:0] p;
        logic [NO-1:0] r;
        for (int t = 0; t < NP; t++) begin
            logic any;
            logic v;
            any = 1'b0;
            v = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (c[t*2*NI + 2*i])   begin any = 1'b1; v = v & xi[i];  end
                if (c[t*2*NI + 2*i+1]) begin any = 1'b1; v = v & ~xi[i]; end
            end
            p[t] = any & v;
        end
        for (int o = 0; o < NO; o++) begin
            r[o] = 1'b0;
            for (int t = 0; t < NP; t++)
                if (c[ANDB + o*NP + t]) r[o] = r[o] | p[t];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // shift the first nbits of c, bit 0 first, then drop load_en
    task automatic load(input logic [TOTAL+7:0] c, input int nbits);
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            load_en = 1'b1;
            cfg_bit = c[b];
        end
        @(negedge clk);
        load_en = 1'b0;
        cfg_bit = 1'b0;
    endtask

    task automatic sweep(input logic [TOTAL-1:0] c, input string req);
        for (int v = 0; v < (1 << NI); v++) begin
            x = NI'(v);
            #1;
            check(y === model(c, NI'(v)), req, 32'(y), 32'(model(c, NI'(v))));
        end
    endtask

    function automatic logic [TOTAL-1:0] ref_cfg();
        logic [TOTAL-1:0] c = '0;
        // inputs x1,x2,x3 -> x[0],x[1],x[2]; literal 2i true, 2i+1 complement
        c[0*6 + 0] = 1; c[0*6 + 2] = 1;                  // P1 = x1 x2
        c[1*6 + 0] = 1; c[1*6 + 5] = 1;                  // P2 = x1 x3'
        c[2*6 + 1] = 1; c[2*6 + 3] = 1; c[2*6 + 4] = 1;  // P3 = x1' x2' x3
        c[3*6 + 0] = 1; c[3*6 + 4] = 1;                  // P4 = x1 x3
        c[ANDB + 0] = 1; c[ANDB + 1] = 1; c[ANDB + 2] = 1;          // f1
        c[ANDB + NP + 0] = 1; c[ANDB + NP + 2] = 1; c[ANDB + NP + 3] = 1; // f2
        return c;
    endfunction

    initial begin
        logic [TOTAL-1:0] c;
        logic [TOTAL+7:0] ext;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        x = '1;
        #1;
        check(y == '0, "R1 y after reset", 32'(y), 0);
        check(config_done == 1'b0, "R1 done after reset", 32'(config_done), 0);
        rst_n = 1'b1;

        // R7: not done one bit short, R8: outputs still zero
        c = ref_cfg();
        for (int b = 0; b < TOTAL - 1; b++) begin
            @(negedge clk); load_en = 1'b1; cfg_bit = c[b];
        end
        @(negedge clk);
        check(config_done == 1'b0, "R7 done early", 32'(config_done), 0);
        check(y == '0, "R8 y before full config", 32'(y), 0);
        cfg_bit = c[TOTAL-1];
        @(negedge clk);
        load_en = 1'b0;
        check(config_done == 1'b1, "R7 done after last bit", 32'(config_done), 1);
        check(y == '0, "R6 y at edge after load", 32'(y), 0);
        @(negedge clk);
        // R9 R4: reference functions with a shared term
        sweep(c, "R9 R4 reference");
        x = 3'b111; #1;
        check(y == 2'b11, "R4 shared term x1x2", 32'(y), 3);

        // R5: empty terms, all connected
        c = '0;
        c[TOTAL-1:ANDB] = '1;
        load(TOTAL'(c), TOTAL);
        @(negedge clk);
        sweep(c, "R5 empty terms");
        // R5: contradictory literals
        c = '0;
        for (int t = 0; t < NP; t++) begin c[t*6 + 2] = 1; c[t*6 + 3] = 1; end
        c[TOTAL-1:ANDB] = '1;
        load(TOTAL'(c), TOTAL);
        @(negedge clk);
        sweep(c, "R5 contradiction");

        // R6: outputs zero mid-load although prior config drives 1
        c = '0;
        c[0] = 1; c[ANDB] = 1; c[ANDB + NP] = 1; // term0 = x0 on both outputs
        load(TOTAL'(c), TOTAL);
        @(negedge clk);
        x = 3'b001; #1;
        check(y == 2'b11, "R3 true literal", 32'(y), 3);
        @(negedge clk); load_en = 1'b1; cfg_bit = 1'b0;
        @(negedge clk);
        check(y == '0, "R6 y during load", 32'(y), 0);
        check(config_done == 1'b1, "R7 done stays", 32'(config_done), 1);
        load_en = 1'b0;
        @(negedge clk);

        // R2: extra bits, last TOTAL define the config
        c = ref_cfg();
        ext = {c, 8'h5A};
        load(ext, TOTAL + 8);
        @(negedge clk);
        sweep(c, "R2 overlong stream");

        // R9 R3: random configurations
        for (int n = 0; n < 25; n++) begin
            for (int b = 0; b < TOTAL; b++) c[b] = 1'($urandom());
            load(TOTAL'(c), TOTAL);
            @(negedge clk);
            sweep(c, "R9 R3 random");
        end

        // R1: reset clears everything
        rst_n = 1'b0; #1;
        check(config_done == 1'b0 && y == '0, "R1 reset again", {y, config_done}, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule